// File: doc/BRIEF.md
# Exception Cause Detection and Vectoring Unit

This block sits next to a small processor core. Each cycle it looks at a set of exception conditions and picks one of them. The conditions are a breakpoint match on the next instruction to complete, a store that needs its translation serviced, and a synchronised system-management request. The unit reports the winner as a one-cycle-registered strobe with a 20-bit vector offset.

Next to the strobe it registers a 3-bit code for the most important misalignment cause reported by the load/store path. The core uses this code to classify an alignment fault.

Once the strobe is raised, the unit freezes its outputs and ignores every new condition. It releases them only when the core pulses an acknowledge, so the core can read the vector at its own pace. Register bits use big-endian numbering: bit 0 is the most significant bit of a 32-bit word.

Top module: `exc_vector_unit`

## Requirements
- R1: A raised strobe carries only one of three vector offsets: 0x01200 for a store translation fault, 0x01300 for an instruction breakpoint, 0x01400 for a system-management interrupt.
- R2: No offset in the reserved span 0x01500–0x02FFF is ever produced. While the strobe is low the vector output reads 0.
- R3: A store (`st_valid`=1) whose address misses in the data TLB (`dtlb_hit`=0) raises the store translation fault.
- R4: A store that hits in the data TLB also raises the store translation fault when its page's changed bit is still clear (`dtlb_chg_set`=0). A hit with `dtlb_chg_set`=1 raises nothing.
- R5: A breakpoint fires only when `bkpt_cfg[31:2]` (big-endian bits 0–29) equals `next_pc[31:2]` and `bkpt_cfg[1]` (big-endian bit 30, the enable) is 1. `next_pc[1:0]` and `bkpt_cfg[0]` are ignored.
- R6: `smi_req` passes through a two-flop synchronizer and is then gated by `msr_ee`. With `msr_ee`=1, a request present before edge 1 raises the strobe after edge 3 and not earlier. With `msr_ee`=0 it never raises the strobe.
- R7: When several conditions are pending in the same cycle, only one is reported. The order is breakpoint first, then store translation fault, then system-management interrupt.
- R8: `align_code` gives the highest-ranked active flag. `align_flags[0]` (floating-point operand not word-aligned) gives code 1. `align_flags[1]` (load/store-multiple or reservation operand not word-aligned) gives 2. `align_flags[2]` (external-control operand misaligned) gives 3. `align_flags[3]` (multiple/string access in little-endian mode) gives 4. No flag gives 0.
- R9: While no exception is held, the strobe, vector and `align_code` reflect the inputs sampled at the previous clock edge.
- R10: While the strobe is high, the strobe, vector and `align_code` hold and all new conditions are ignored. An edge with `exc_ack`=1 clears all three outputs to 0 at that edge, and conditions are evaluated again from the next edge.
- R11: A synchronous active-low reset clears the strobe, vector, `align_code` and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| next_pc | input | 32 | Address of the next instruction to complete |
| bkpt_cfg | input | 32 | Breakpoint word: compare address in [31:2], enable in [1] |
| msr_ee | input | 1 | Machine-state external interrupt enable |
| smi_req | input | 1 | Asynchronous level system-management request |
| st_valid | input | 1 | A store is being translated this cycle |
| dtlb_hit | input | 1 | Data TLB lookup hit for the store |
| dtlb_chg_set | input | 1 | Changed bit of the hit page is already set |
| align_flags | input | 4 | Misalignment cause flags, see R8 |
| exc_ack | input | 1 | Core acknowledge of the held exception |
| exc_taken | output | 1 | Exception strobe, held until acknowledged |
| exc_vector | output | 20 | Vector offset of the reported exception |
| align_code | output | 3 | Ranked alignment cause code |

## Verification
Suppose the arbitration or hold state were wrong. The next acknowledge would show it at once: a second vector would appear or the strobe would stay up, one edge after the stimulus that should have been ignored or cleared. A synchronizer that is too short or too long moves the interrupt strobe by a whole edge. So the bench samples at exactly the second and third edge after a request. A wrong cause ranking shows on `align_code` one edge after the flags change, and each ranking boundary is driven on its own.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception vectoring unit.
// Assumes a 20-bit vector offset space; only three offsets are legal outputs.
package exc_pkg;
    localparam int VEC_W = 20;

    localparam logic [VEC_W-1:0] VEC_NONE  = 20'h00000;
    localparam logic [VEC_W-1:0] VEC_STORE = 20'h01200;
    localparam logic [VEC_W-1:0] VEC_BKPT  = 20'h01300;
    localparam logic [VEC_W-1:0] VEC_SMI   = 20'h01400;
    localparam logic [VEC_W-1:0] VEC_RSV_LO = 20'h01500;
    localparam logic [VEC_W-1:0] VEC_RSV_HI = 20'h02FFF;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BKPT  = 2'd1,
        SRC_STORE = 2'd2,
        SRC_SMI   = 2'd3
    } exc_src_e;

    // Map a winning source to its vector offset.
    function automatic logic [VEC_W-1:0] vec_of(exc_src_e src);
        case (src)
            SRC_BKPT:  return VEC_BKPT;
            SRC_STORE: return VEC_STORE;
            SRC_SMI:   return VEC_SMI;
            default:   return VEC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/exc_bkpt_match.sv
// Instruction breakpoint comparator.
// Assumes big-endian bit numbering: bits 0..29 of the register are [ADDR_W-1:2],
// bit 30 is the enable at [1]. The two low address bits are ignored (word compare).
module exc_bkpt_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [ADDR_W-1:0] bkpt_cfg,
    output logic              hit
);
    localparam int EN_BIT = 1;

    logic unused_bits;

    // Word-address compare qualified by the enable bit.
    assign hit = bkpt_cfg[EN_BIT] && (bkpt_cfg[ADDR_W-1:2] == next_pc[ADDR_W-1:2]);

    // Bits that play no part in the compare.
    assign unused_bits = ^{bkpt_cfg[0], next_pc[1:0]};
endmodule

// File: rtl/exc_smi_sync.sv
// Multi-flop synchronizer for the level-sensitive system-management request.
// Assumes STAGES >= 2; reset is synchronous and active low.
module exc_smi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_sync
);
    logic [STAGES-1:0] shreg;

    // Shift the request through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], req_async};
        end
    end

    assign req_sync = shreg[STAGES-1];
endmodule

// File: rtl/exc_align_rank.sv
// Priority encoder for alignment fault causes.
// Assumes flags[0] is the highest-ranked cause; code i+1 names flags[i], code 0 none.
module exc_align_rank #(
    parameter int NUM_CAUSE = 4,
    parameter int CODE_W    = $clog2(NUM_CAUSE + 1)
) (
    input  logic [NUM_CAUSE-1:0] flags,
    output logic [CODE_W-1:0]    code
);
    // Scan from lowest to highest rank so the highest active cause wins.
    always_comb begin
        code = '0;
        for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
            if (flags[i]) begin
                code = CODE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/exc_vector_unit.sv
// Exception cause detection and vectoring unit (top).
// Detects breakpoint, store translation fault and gated system-management
// interrupt, arbitrates them in a fixed order, and registers the winner with
// the ranked alignment cause. Outputs hold until exc_ack. Synchronous active-low reset.
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_ALIGN   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CODE_W     = $clog2(NUM_ALIGN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    next_pc,
    input  logic [ADDR_W-1:0]    bkpt_cfg,
    input  logic                 msr_ee,
    input  logic                 smi_req,
    input  logic                 st_valid,
    input  logic                 dtlb_hit,
    input  logic                 dtlb_chg_set,
    input  logic [NUM_ALIGN-1:0] align_flags,
    input  logic                 exc_ack,
    output logic                 exc_taken,
    output logic [VEC_W-1:0]     exc_vector,
    output logic [CODE_W-1:0]    align_code
);
    logic        bkpt_hit;
    logic        smi_sync;
    logic        smi_fire;
    logic        store_fault;
    logic [CODE_W-1:0] align_next;
    exc_src_e    src_win;

    exc_bkpt_match #(.ADDR_W(ADDR_W)) u_bkpt (
        .next_pc  (next_pc),
        .bkpt_cfg (bkpt_cfg),
        .hit      (bkpt_hit)
    );

    exc_smi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (smi_req),
        .req_sync  (smi_sync)
    );

    exc_align_rank #(.NUM_CAUSE(NUM_ALIGN), .CODE_W(CODE_W)) u_rank (
        .flags (align_flags),
        .code  (align_next)
    );

    // Store fault: TLB miss, or hit whose changed bit still needs setting.
    assign store_fault = st_valid && (!dtlb_hit || !dtlb_chg_set);

    // Synchronized interrupt qualified by the machine-state enable.
    assign smi_fire = smi_sync && msr_ee;

    // Fixed-order arbitration: breakpoint, then store fault, then interrupt.
    always_comb begin
        if (bkpt_hit)         src_win = SRC_BKPT;
        else if (store_fault) src_win = SRC_STORE;
        else if (smi_fire)    src_win = SRC_SMI;
        else                  src_win = SRC_NONE;
    end

    // Output register: capture when idle, hold while taken, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_taken  <= 1'b0;
            exc_vector <= VEC_NONE;
            align_code <= '0;
        end else if (exc_taken) begin
            if (exc_ack) begin
                exc_taken  <= 1'b0;
                exc_vector <= VEC_NONE;
                align_code <= '0;
            end
        end else begin
            exc_taken  <= (src_win != SRC_NONE);
            exc_vector <= vec_of(src_win);
            align_code <= align_next;
        end
    end

    // R1: only the three legal offsets accompany the strobe.
    p_vec_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (exc_vector == VEC_STORE || exc_vector == VEC_BKPT || exc_vector == VEC_SMI));

    // R2: reserved span never appears; idle vector is zero.
    p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_vector >= VEC_RSV_LO && exc_vector <= VEC_RSV_HI));
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken |-> (exc_vector == VEC_NONE));

    // R7: a breakpoint seen while idle always wins the next report.
    p_bkpt_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_taken && bkpt_hit) |=> (exc_taken && exc_vector == VEC_BKPT));

    // R3: a store fault without a breakpoint is reported as such.
    p_store_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_taken && !bkpt_hit && store_fault) |=> (exc_vector == VEC_STORE));

    // R8: highest-ranked cause appears one edge later while idle.
    p_top_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_taken && align_flags[0]) |=> (align_code == CODE_W'(1)));
    p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        align_code <= CODE_W'(NUM_ALIGN));

    // R10: outputs hold until acknowledged, then clear.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && !exc_ack) |=> (exc_taken && $stable(exc_vector) && $stable(align_code)));
    p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && exc_ack) |=> !exc_taken);
endmodule

// File: tb/exc_vector_unit_tb_top.sv
// Directed bench for exc_vector_unit: one task per scenario, 250 MHz clock.
module exc_vector_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] next_pc;
    logic [31:0] bkpt_cfg;
    logic        msr_ee;
    logic        smi_req;
    logic        st_valid;
    logic        dtlb_hit;
    logic        dtlb_chg_set;
    logic [3:0]  align_flags;
    logic        exc_ack;
    logic        exc_taken;
    logic [19:0] exc_vector;
    logic [2:0]  align_code;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    exc_vector_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .next_pc      (next_pc),
        .bkpt_cfg     (bkpt_cfg),
        .msr_ee       (msr_ee),
        .smi_req      (smi_req),
        .st_valid     (st_valid),
        .dtlb_hit     (dtlb_hit),
        .dtlb_chg_set (dtlb_chg_set),
        .align_flags  (align_flags),
        .exc_ack      (exc_ack),
        .exc_taken    (exc_taken),
        .exc_vector   (exc_vector),
        .align_code   (align_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic quiet();
        next_pc      = 32'h0000_4000;
        bkpt_cfg     = 32'h0;
        msr_ee       = 1'b0;
        smi_req      = 1'b0;
        st_valid     = 1'b0;
        dtlb_hit     = 1'b1;
        dtlb_chg_set = 1'b1;
        align_flags  = 4'b0;
        exc_ack      = 1'b0;
    endtask

    // Acknowledge with quiet inputs and confirm the release (R10).
    task automatic do_ack(input string tag);
        quiet();
        exc_ack = 1'b1;
        step();
        chk({tag, " R10 ack clears strobe"}, {31'b0, exc_taken}, 32'd0);
        chk({tag, " R2 idle vector zero"}, {12'b0, exc_vector}, 32'd0);
        exc_ack = 1'b0;
    endtask

    task automatic t_reset();
        quiet();
        rst_n = 1'b0;
        smi_req = 1'b1;
        msr_ee = 1'b1;
        step(4);
        smi_req = 1'b0;
        msr_ee = 1'b0;
        rst_n = 1'b1;
        chk("R11 strobe after reset", {31'b0, exc_taken}, 32'd0);
        chk("R11 vector after reset", {12'b0, exc_vector}, 32'd0);
        chk("R11 code after reset", {29'b0, align_code}, 32'd0);
        step(3);
        chk("R11 synchronizer cleared", {31'b0, exc_taken}, 32'd0);
    endtask

    task automatic t_store();
        quiet();
        st_valid = 1'b1; dtlb_hit = 1'b0;
        step();
        chk("R3 miss strobe", {31'b0, exc_taken}, 32'd1);
        chk("R1 R3 miss vector", {12'b0, exc_vector}, 32'h01200);
        do_ack("store miss");
        st_valid = 1'b1; dtlb_hit = 1'b1; dtlb_chg_set = 1'b0;
        step();
        chk("R4 hit clean vector", {12'b0, exc_vector}, 32'h01200);
        do_ack("store hit clean");
        st_valid = 1'b1; dtlb_hit = 1'b1; dtlb_chg_set = 1'b1;
        step(2);
        chk("R4 hit changed no strobe", {31'b0, exc_taken}, 32'd0);
        st_valid = 1'b0; dtlb_hit = 1'b0;
        step(2);
        chk("R3 no store no strobe", {31'b0, exc_taken}, 32'd0);
    endtask

    task automatic t_bkpt();
        quiet();
        next_pc  = 32'h0012_3457;
        bkpt_cfg = 32'h0012_3456 | 32'h2 | 32'h1;
        step();
        chk("R5 match low bits differ", {31'b0, exc_taken}, 32'd1);
        chk("R1 R5 bkpt vector", {12'b0, exc_vector}, 32'h01300);
        do_ack("bkpt");
        next_pc  = 32'h0012_3454;
        bkpt_cfg = 32'h0012_3454;
        step();
        chk("R5 enable clear no strobe", {31'b0, exc_taken}, 32'd0);
        bkpt_cfg = 32'h0012_3450 | 32'h2;
        step();
        chk("R5 bit2 mismatch no strobe", {31'b0, exc_taken}, 32'd0);
        bkpt_cfg = 32'h8012_3454 | 32'h2;
        step();
        chk("R5 msb mismatch no strobe", {31'b0, exc_taken}, 32'd0);
    endtask

    task automatic t_smi();
        quiet();
        msr_ee = 1'b1; smi_req = 1'b1;
        step(2);
        chk("R6 not before third edge", {31'b0, exc_taken}, 32'd0);
        step();
        chk("R6 strobe at third edge", {31'b0, exc_taken}, 32'd1);
        chk("R1 R6 smi vector", {12'b0, exc_vector}, 32'h01400);
        smi_req = 1'b0; msr_ee = 1'b0;
        step(3);
        do_ack("smi");
        smi_req = 1'b1; msr_ee = 1'b0;
        step(4);
        chk("R6 gated by enable", {31'b0, exc_taken}, 32'd0);
        smi_req = 1'b0;
        step(3);
    endtask

    task automatic t_priority();
        quiet();
        smi_req = 1'b1;
        step(3);
        msr_ee = 1'b1; st_valid = 1'b1; dtlb_hit = 1'b0;
        step();
        chk("R7 store over smi", {12'b0, exc_vector}, 32'h01200);
        smi_req = 1'b0; msr_ee = 1'b0;
        step(3);
        do_ack("prio1");
        st_valid = 1'b1; dtlb_hit = 1'b0;
        next_pc = 32'h0000_1000; bkpt_cfg = 32'h0000_1002;
        step();
        chk("R7 bkpt over store", {12'b0, exc_vector}, 32'h01300);
        do_ack("prio2");
    endtask

    task automatic t_align();
        logic [3:0] pats [5] = '{4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000};
        logic [2:0] exps [5] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd0};
        quiet();
        for (int i = 0; i < 5; i++) begin
            align_flags = pats[i];
            step();
            chk($sformatf("R8 R9 code for flags %b", pats[i]), {29'b0, align_code}, {29'b0, exps[i]});
        end
        align_flags = 4'b0101;
        step();
        chk("R8 sparse flags", {29'b0, align_code}, 32'd1);
        align_flags = 4'b1010;
        step();
        chk("R8 sparse flags 2", {29'b0, align_code}, 32'd2);
    endtask

    task automatic t_hold();
        quiet();
        st_valid = 1'b1; dtlb_hit = 1'b0; align_flags = 4'b0100;
        step();
        chk("R10 taken", {12'b0, exc_vector}, 32'h01200);
        chk("R10 code captured", {29'b0, align_code}, 32'd3);
        st_valid = 1'b0;
        next_pc = 32'h0000_2000; bkpt_cfg = 32'h0000_2002;
        align_flags = 4'b0001;
        step(3);
        chk("R10 vector held", {12'b0, exc_vector}, 32'h01200);
        chk("R10 code held", {29'b0, align_code}, 32'd3);
        chk("R10 strobe held", {31'b0, exc_taken}, 32'd1);
        do_ack("hold");
        step();
        chk("R10 resumes after ack", {31'b0, exc_taken}, 32'd0);
    endtask

    initial begin
        #100000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_store();
        t_bkpt();
        t_smi();
        t_priority();
        t_align();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule